// File: doc/BRIEF.md
# Thirty-Two-Bit Integer ALU with Shared Add/Subtract Path

This block is a purely combinational arithmetic and logic unit for a single-cycle integer datapath. It takes two 32-bit operands and a 4-bit operation code, and returns a 32-bit result together with a zero flag and a signed overflow flag. It covers four bitwise operations, addition, subtraction and a signed less-than compare.

One adder serves addition, subtraction and the compare. The high bit of the operation code selects whether the second operand enters the adder as is or inverted, with a carry-in of one. The compare takes its answer from the adder's sign and overflow, so it stays correct when the difference overflows. A separate decoder turns the operation code into a small bundle of strobes. The datapath follows those strobes and does not decode the code itself.

Top module: `aluCore`

## Requirements
- R1: Code 4'b0000 returns opA AND opB bitwise; code 4'b0001 returns opA OR opB bitwise.
- R2: Code 4'b0010 returns opA XOR opB bitwise; code 4'b0011 returns NOT (opA OR opB) bitwise.
- R3: Code 4'b0110 returns opA + opB modulo 2^32.
- R4: Code 4'b1110 returns opA - opB modulo 2^32. Bit 3 of the code selects subtraction in the shared adder.
- R5: Code 4'b1111 returns 1 in bit 0 when opA < opB as two's-complement signed values, and 0 otherwise. Bits 31..1 are always 0, including when opA - opB overflows.
- R6: ovfFlag is 1 only for codes 4'b0110 and 4'b1110, and only when the true signed sum or difference lies outside [-2^31, 2^31-1]. For every other code it is 0.
- R7: zeroFlag is 1 exactly when all 32 bits of result are 0, for every code.
- R8: Any code other than 0000, 0001, 0010, 0011, 0110, 1110 and 1111 returns result 0 with ovfFlag 0, and therefore zeroFlag 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | Result is all zeros |
| ovfFlag | output | 1 | Signed overflow of add or subtract |

## Verification
The block holds no state, so any fault appears at the ports in the same cycle as the stimulus.

- A wrong strobe from the decoder shows up as a result from the wrong unit, or as a stray overflow flag on a logic code.
- A wrong invert or carry-in in the adder is off by one, or sign-flipped, only for certain operand pairs.

For this reason every code is swept against boundary operands and pseudo-random operands. The boundary operands are 0, ±1, the most positive and most negative values, and alternating bit patterns. Each result is compared with arithmetic computed in 64-bit signed integers.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [3:0] {
    CODE_AND = 4'b0000,
    CODE_OR  = 4'b0001,
    CODE_XOR = 4'b0010,
    CODE_NOR = 4'b0011,
    CODE_ADD = 4'b0110,
    CODE_SUB = 4'b1110,
    CODE_SLT = 4'b1111
  } aluCodeE;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logicSelE;

  typedef struct packed {
    logic     valid;     // code is one of the listed operations
    logic     useArith;  // result comes from the adder sum
    logic     useSlt;    // result is the signed less-than bit
    logic     invertB;   // adder sees ~B with carry-in 1
    logicSelE logicSel;  // which bitwise function
  } aluStrobesT;

endpackage

// File: rtl/aluDecode.sv
module aluDecode
  import aluPkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] opSel,
  output aluStrobesT        strobes
);

  localparam int SUB_BIT = CODE_W - 1;

  always_comb begin
    strobes          = '0;
    strobes.logicSel = LG_AND;
    case (opSel)
      CODE_AND: begin
        strobes.valid    = 1'b1;
        strobes.logicSel = LG_AND;
      end
      CODE_OR: begin
        strobes.valid    = 1'b1;
        strobes.logicSel = LG_OR;
      end
      CODE_XOR: begin
        strobes.valid    = 1'b1;
        strobes.logicSel = LG_XOR;
      end
      CODE_NOR: begin
        strobes.valid    = 1'b1;
        strobes.logicSel = LG_NOR;
      end
      CODE_ADD, CODE_SUB: begin
        strobes.valid    = 1'b1;
        strobes.useArith = 1'b1;
        strobes.invertB  = opSel[SUB_BIT];
      end
      CODE_SLT: begin
        strobes.valid   = 1'b1;
        strobes.useSlt  = 1'b1;
        strobes.invertB = opSel[SUB_BIT];
      end
      default: strobes = '0;
    endcase
  end

  // Each listed code raises at most one of the result-source strobes.
  always_comb begin
    if (!$isunknown(strobes)) begin
      a_r8_one_source: assert ($onehot0({strobes.useArith, strobes.useSlt}))
        else $error("R8: decode raised more than one result source");
    end
  end

endmodule

// File: rtl/aluAdder.sv
module aluAdder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             invertB,
  output logic [WIDTH-1:0] sum,
  output logic             signedOvf
);

  localparam int LOW_W = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH:0]   fullSum;
  logic [LOW_W:0]   lowSum;
  logic             carryIntoMsb;
  logic             carryOutMsb;

  // Subtraction: invert B and force the carry-in to one.
  assign bEff    = invertB ? ~addB : addB;
  assign fullSum = {1'b0, addA} + {1'b0, bEff} + {{WIDTH{1'b0}}, invertB};
  assign lowSum  = {1'b0, addA[LOW_W-1:0]} + {1'b0, bEff[LOW_W-1:0]}
                 + {{LOW_W{1'b0}}, invertB};

  assign carryIntoMsb = lowSum[LOW_W];
  assign carryOutMsb  = fullSum[WIDTH];
  assign sum          = fullSum[WIDTH-1:0];
  assign signedOvf    = carryIntoMsb ^ carryOutMsb;

  always_comb begin
    if (!$isunknown({addA, addB, invertB})) begin
      // R6: overflow means both adder inputs share a sign and the sum has the other sign.
      a_r6_ovf_sign: assert (!signedOvf ||
                             ((addA[WIDTH-1] == bEff[WIDTH-1]) && (sum[WIDTH-1] != addA[WIDTH-1])))
        else $error("R6: overflow flagged without a sign mismatch");
      a_r6_ovf_found: assert (signedOvf ||
                              !((addA[WIDTH-1] == bEff[WIDTH-1]) && (sum[WIDTH-1] != addA[WIDTH-1])))
        else $error("R6: sign mismatch without overflow");
    end
  end

endmodule

// File: rtl/aluLogic.sv
module aluLogic
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] lgA,
  input  logic [WIDTH-1:0] lgB,
  input  logicSelE         logicSel,
  output logic [WIDTH-1:0] lgOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : gSlice
    always_comb begin
      case (logicSel)
        LG_AND:  lgOut[i] = lgA[i] & lgB[i];
        LG_OR:   lgOut[i] = lgA[i] | lgB[i];
        LG_XOR:  lgOut[i] = lgA[i] ^ lgB[i];
        default: lgOut[i] = ~(lgA[i] | lgB[i]);
      endcase
    end
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobesT       strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag
);

  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] lgOut;
  logic             adderOvf;
  logic             lessThan;

  aluAdder #(.WIDTH(WIDTH)) uAdder (
    .addA     (opA),
    .addB     (opB),
    .invertB  (strobes.invertB),
    .sum      (sum),
    .signedOvf(adderOvf)
  );

  aluLogic #(.WIDTH(WIDTH)) uLogic (
    .lgA     (opA),
    .lgB     (opB),
    .logicSel(strobes.logicSel),
    .lgOut   (lgOut)
  );

  // The sign of A-B corrected by overflow gives the signed compare.
  assign lessThan = sum[WIDTH-1] ^ adderOvf;

  always_comb begin
    if (!strobes.valid)        result = '0;
    else if (strobes.useArith) result = sum;
    else if (strobes.useSlt)   result = {{(WIDTH-1){1'b0}}, lessThan};
    else                       result = lgOut;
  end

  assign ovfFlag  = strobes.valid & strobes.useArith & adderOvf;
  assign zeroFlag = ~|result;

  always_comb begin
    if (!$isunknown({opA, opB, strobes})) begin
      a_r3_add_sum: assert (!(strobes.valid && strobes.useArith && !strobes.invertB) ||
                            (result == opA + opB))
        else $error("R3: add result wrong");
      a_r4_sub_sum: assert (!(strobes.valid && strobes.useArith && strobes.invertB) ||
                            (result == opA - opB))
        else $error("R4: subtract result wrong");
      a_r5_slt_value: assert (!(strobes.valid && strobes.useSlt) ||
                              (result == (($signed(opA) < $signed(opB)) ? WIDTH'(1) : WIDTH'(0))))
        else $error("R5: compare result wrong");
      a_r6_no_ovf_logic: assert (strobes.useArith || !ovfFlag)
        else $error("R6: overflow on a non-arithmetic code");
    end
  end

endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int CODE_W = 4
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [CODE_W-1:0] opSel,
  output logic [WIDTH-1:0]  result,
  output logic              zeroFlag,
  output logic              ovfFlag
);

  aluStrobesT strobes;

  aluDecode #(.CODE_W(CODE_W)) uDecode (
    .opSel  (opSel),
    .strobes(strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) uDatapath (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .zeroFlag(zeroFlag),
    .ovfFlag (ovfFlag)
  );

  logic listedCode;
  always_comb begin
    listedCode = (opSel == 4'b0000) || (opSel == 4'b0001) || (opSel == 4'b0010) ||
                 (opSel == 4'b0011) || (opSel == 4'b0110) || (opSel == 4'b1110) ||
                 (opSel == 4'b1111);
  end

  always_comb begin
    if (!$isunknown({opA, opB, opSel})) begin
      a_r8_unlisted_quiet: assert (listedCode || (result == '0 && !ovfFlag))
        else $error("R8: unlisted code produced output");
    end
  end

endmodule

// File: tb/aluCore_test.sv
module aluCore_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opSel = '0;
  logic [31:0] result;
  logic        zeroFlag;
  logic        ovfFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  aluCore uut (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .zeroFlag(zeroFlag), .ovfFlag(ovfFlag)
  );

  function automatic string tagFor(input logic [3:0] c);
    case (c)
      4'b0000, 4'b0001: return "R1";
      4'b0010, 4'b0011: return "R2";
      4'b0110:          return "R3";
      4'b1110:          return "R4";
      4'b1111:          return "R5";
      default:          return "R8";
    endcase
  endfunction

  function automatic void model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] r, output logic ov);
    longint sa, sb, t;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ov = 1'b0;
    case (c)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b0010: r = a ^ b;
      4'b0011: r = ~(a | b);
      4'b0110: begin t = sa + sb; r = t[31:0]; ov = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'b1110: begin t = sa - sb; r = t[31:0]; ov = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'b1111: r = (sa < sb) ? 32'd1 : 32'd0;
      default: r = 32'd0;
    endcase
  endfunction

  task automatic checkVec(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] expR;
    logic        expO;
    logic        expZ;
    model(c, a, b, expR, expO);
    expZ = (expR == 32'd0);
    @(posedge clk);
    opSel = c; opA = a; opB = b;
    @(negedge clk);
    checks++;
    if (result !== expR) begin
      errors++;
      $display("FAIL %s result code=%b a=%h b=%h actual %h expected %h", tagFor(c), c, a, b, result, expR);
    end
    checks++;
    if (ovfFlag !== expO) begin
      errors++;
      $display("FAIL R6 ovf code=%b a=%h b=%h actual %b expected %b", c, a, b, ovfFlag, expO);
    end
    checks++;
    if (zeroFlag !== expZ) begin
      errors++;
      $display("FAIL R7 zero code=%b a=%h b=%h actual %b expected %b", c, a, b, zeroFlag, expZ);
    end
  endtask

  logic [31:0] corner [8];
  logic [31:0] lfsr = 32'hACE1_2468;

  function automatic logic [31:0] nextLfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h5555_5555;
    corner[6] = 32'hAAAA_AAAA; corner[7] = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state check: zero inputs, code 0000 (R1, R7).
    @(negedge clk);
    checks++;
    if (result !== 32'd0 || zeroFlag !== 1'b1 || ovfFlag !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state actual %h/%b/%b expected 0/1/0", result, zeroFlag, ovfFlag);
    end
    // Corner sweep over all 16 codes: R1..R8.
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          checkVec(4'(c), corner[i], corner[j]);
    // Directed overflow boundaries (R6) and compare under overflow (R5).
    checkVec(4'b0110, 32'h7FFF_FFFF, 32'h0000_0001);
    checkVec(4'b0110, 32'h8000_0000, 32'hFFFF_FFFF);
    checkVec(4'b1110, 32'h8000_0000, 32'h0000_0001);
    checkVec(4'b1110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    checkVec(4'b1111, 32'h8000_0000, 32'h0000_0001);
    checkVec(4'b1111, 32'h7FFF_FFFF, 32'h8000_0000);
    checkVec(4'b1110, 32'h0000_0005, 32'h0000_0005);
    // Pseudo-random operands on every code.
    for (int n = 0; n < 300; n++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      lfsr = nextLfsr(lfsr); ra = lfsr;
      lfsr = nextLfsr(lfsr); rb = lfsr;
      for (int c = 0; c < 16; c++) checkVec(4'(c), ra, rb);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule